// File: doc/BRIEF.md
# General Purpose Compare Timer

This block is an up-counting timer with a small register file and three compare channels. Software writes a control word, a prescale divisor, an interrupt-enable mask, three compare values and, if it needs to, the count itself. It reads all of these back, along with a status word of sticky event flags. The counter advances on every enabled cycle, scaled down by the prescaler. The block runs from one clock, and a clock-enable input qualifies each count tick.

The mode bit picks one of two behaviours. In free-run mode the count wraps from all-ones to zero. In restart mode the count goes back to zero on the step that follows a match with compare channel 1. Compare matches and the wrap each raise their own flag. A mask at the same bit positions picks which flags drive the single registered interrupt output.

A clock-source field is stored for software but has no effect. A software-reset bit returns the whole block to its reset state.

Top module: `cmp_timer`

## Requirements
- R1: The count advances only on a cycle where the enable bit (control bit 0) is 1 and `tick_en` is 1. When the enable bit is 0, the count holds its value.
- R2: With control bit 9 set to 1 (free-run), the count goes from all-ones to 0 on a step.
- R3: With control bit 9 set to 0 (restart), a step taken while the count equals compare 1 loads 0. Any write to compare 1 in this mode also sets the count to 0.
- R4: Status bits 0, 1 and 2 set on a step taken while the count equals compare 1, 2 or 3. Status bit 5 sets on a step taken from all-ones.
- R5: Status flags are sticky. Writing 1 to a status bit clears it. A set in the same cycle as a clear wins.
- R6: `irq` is a register. It holds the OR of (status AND interrupt enable) from the previous cycle. The enable bits are 0, 1, 2 and 5.
- R7: The prescale register (low 12 bits) divides the step rate by its value plus 1. A value of 0 steps on every enabled tick.
- R8: When a control write turns the enable bit from 0 to 1 with control bit 1 also set, the count and the prescale phase restart from 0. Without bit 1, the count resumes from its held value.
- R9: Writing 1 to control bits 29, 30 or 31 sets status bit 0, 1 or 2. These control bits always read as 0.
- R10: Writing 1 to control bit 15 returns every register, the count and the prescale phase to their reset values. Bit 15 reads as 0.
- R11: Addresses: 0 control, 1 prescale, 2 status, 3 interrupt enable, 4 to 6 compare 1 to 3, 7 count. Control keeps bits 0, 1, 6 to 8 and 9. Reset values are 0 for every register except the compares, which reset to all-ones.
- R12: A write to address 7 loads the count directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Clock enable for count ticks |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Combined registered interrupt |

## Verification
The count is checked cycle by cycle over a sweep of prescale values 0 to 3. Each value is run once with `tick_en` held high and once with it toggling, which separates divisor errors from tick-gating errors. A free-run run started just below all-ones shows the wrap, the rollover flag and the compare flags landing on the same step. A restart sweep with compare 1 at 5 checks the six-cycle period and the exact cycle the flag rises. Separate sequences cover:
- disabling and re-enabling with and without the restart bit;
- forced events;
- software reset.

These sequences show that the count holds, resumes or restarts as the requirements say.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int NUM_CH = 3;
  localparam int FLAG_W = 6;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRESC = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP1  = 3'd4;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd7;

  localparam int CB_EN     = 0;
  localparam int CB_ENMODE = 1;
  localparam int CB_CLK_LO = 6;
  localparam int CB_FREE   = 9;
  localparam int CB_SWR    = 15;
  localparam int CB_FRC_LO = 29;

  localparam int SB_ROLL = 5;
  localparam logic [FLAG_W-1:0] FLAG_MASK = 6'b100111;
endpackage

// File: rtl/cmp_timer_rst_sync.sv
module cmp_timer_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;
endmodule

// File: rtl/cmp_timer_prescaler.sv
module cmp_timer_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  output logic             step
);
  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] phase_d;
  logic             at_end;

  assign at_end = (phase_q >= div);
  assign step   = run && at_end && !clr;

  always_comb begin
    phase_d = phase_q;
    if (clr) begin
      phase_d = '0;
    end else if (run) begin
      phase_d = at_end ? '0 : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/cmp_timer_match.sv
module cmp_timer_match #(
  parameter int CNT_W = 32,
  parameter int NCH   = 3
) (
  input  logic [CNT_W-1:0]     cnt,
  input  logic [NCH*CNT_W-1:0] cmp_flat,
  output logic [NCH-1:0]       hit
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit[i] = (cnt == cmp_flat[i*CNT_W +: CNT_W]);
  end
endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr,
  input  logic             step,
  input  logic             restart_mode,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_max;
  logic             at_limit;

  assign at_max   = (cnt_q == MAX);
  assign at_limit = restart_mode && (cnt_q == limit);
  assign wrap     = step && at_max;

  always_comb begin
    cnt_d = cnt_q;
    if (swr) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = load_val;
    end else if (clr) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = (at_max || at_limit) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int CMP_BITS = NUM_CH * CNT_W;

  logic rst_sync_n;

  logic             ctrl_en_q,  ctrl_en_d;
  logic             ctrl_em_q,  ctrl_em_d;
  logic             ctrl_fr_q,  ctrl_fr_d;
  logic [2:0]       ctrl_cs_q,  ctrl_cs_d;
  logic [PRE_W-1:0] presc_q,    presc_d;
  logic [FLAG_W-1:0] stat_q,    stat_d;
  logic [FLAG_W-1:0] ien_q,     ien_d;
  logic [CMP_BITS-1:0] cmp_q,   cmp_d;
  logic             irq_q,      irq_d;

  logic              wr_ctrl, swr, en_restart, cmp1_clr, cnt_load, run, step, wrap;
  logic [CNT_W-1:0]  cnt;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] force_ev;
  logic [FLAG_W-1:0] set_vec, clr_vec;
  logic              unused_wr;

  assign unused_wr = ^wr_data;

  cmp_timer_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(rst_sync_n)
  );

  // write decode
  assign wr_ctrl    = wr_en && (wr_addr == A_CTRL);
  assign swr        = wr_ctrl && wr_data[CB_SWR];
  assign en_restart = wr_ctrl && !swr && wr_data[CB_EN] && wr_data[CB_ENMODE] && !ctrl_en_q;
  assign cmp1_clr   = wr_en && (wr_addr == A_CMP1) && !ctrl_fr_q;
  assign cnt_load   = wr_en && (wr_addr == A_COUNT);
  assign run        = ctrl_en_q && tick_en;
  assign force_ev   = (wr_ctrl && !swr) ? wr_data[CB_FRC_LO +: NUM_CH] : '0;

  cmp_timer_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .clr  (swr || en_restart),
    .run  (run),
    .div  (presc_q),
    .step (step)
  );

  cmp_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .swr         (swr),
    .load        (cnt_load),
    .load_val    (wr_data[CNT_W-1:0]),
    .clr         (en_restart || cmp1_clr),
    .step        (step),
    .restart_mode(!ctrl_fr_q),
    .limit       (cmp_q[CNT_W-1:0]),
    .cnt         (cnt),
    .wrap        (wrap)
  );

  cmp_timer_match #(.CNT_W(CNT_W), .NCH(NUM_CH)) u_match (
    .cnt     (cnt),
    .cmp_flat(cmp_q),
    .hit     (hit)
  );

  // flag events
  always_comb begin
    set_vec = '0;
    set_vec[NUM_CH-1:0] = (hit & {NUM_CH{step}}) | force_ev;
    set_vec[SB_ROLL]    = wrap;
    clr_vec = (wr_en && (wr_addr == A_STAT)) ? wr_data[FLAG_W-1:0] : '0;
  end

  // next state of the register file
  always_comb begin
    ctrl_en_d = ctrl_en_q;
    ctrl_em_d = ctrl_em_q;
    ctrl_fr_d = ctrl_fr_q;
    ctrl_cs_d = ctrl_cs_q;
    presc_d   = presc_q;
    ien_d     = ien_q;
    cmp_d     = cmp_q;
    stat_d    = ((stat_q & ~clr_vec) | set_vec) & FLAG_MASK;
    irq_d     = |(stat_q & ien_q);
    if (swr) begin
      ctrl_en_d = 1'b0;
      ctrl_em_d = 1'b0;
      ctrl_fr_d = 1'b0;
      ctrl_cs_d = '0;
      presc_d   = '0;
      ien_d     = '0;
      cmp_d     = '1;
      stat_d    = '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) begin
        ctrl_en_d = wr_data[CB_EN];
        ctrl_em_d = wr_data[CB_ENMODE];
        ctrl_fr_d = wr_data[CB_FREE];
        ctrl_cs_d = wr_data[CB_CLK_LO +: 3];
      end
      if (wr_addr == A_PRESC) presc_d = wr_data[PRE_W-1:0];
      if (wr_addr == A_IEN)   ien_d   = wr_data[FLAG_W-1:0] & FLAG_MASK;
      for (int i = 0; i < NUM_CH; i++) begin
        if (wr_addr == A_CMP1 + ADDR_W'(i)) cmp_d[i*CNT_W +: CNT_W] = wr_data[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_en_q <= 1'b0;
      ctrl_em_q <= 1'b0;
      ctrl_fr_q <= 1'b0;
      ctrl_cs_q <= '0;
      presc_q   <= '0;
      ien_q     <= '0;
      cmp_q     <= '1;
      stat_q    <= '0;
      irq_q     <= 1'b0;
    end else begin
      ctrl_en_q <= ctrl_en_d;
      ctrl_em_q <= ctrl_em_d;
      ctrl_fr_q <= ctrl_fr_d;
      ctrl_cs_q <= ctrl_cs_d;
      presc_q   <= presc_d;
      ien_q     <= ien_d;
      cmp_q     <= cmp_d;
      stat_q    <= stat_d;
      irq_q     <= irq_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[CB_EN]            = ctrl_en_q;
        rd_data[CB_ENMODE]        = ctrl_em_q;
        rd_data[CB_CLK_LO +: 3]   = ctrl_cs_q;
        rd_data[CB_FREE]          = ctrl_fr_q;
      end
      A_PRESC: rd_data[PRE_W-1:0]  = presc_q;
      A_STAT:  rd_data[FLAG_W-1:0] = stat_q;
      A_IEN:   rd_data[FLAG_W-1:0] = ien_q;
      A_COUNT: rd_data[CNT_W-1:0]  = cnt;
      default: rd_data[CNT_W-1:0]  = cmp_q[(rd_addr - A_CMP1) * CNT_W +: CNT_W];
    endcase
  end

  assign irq = irq_q;
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             en,
  input logic             freerun,
  input logic             step,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp1,
  input logic [5:0]       stat,
  input logic [5:0]       ien,
  input logic             irq
);
  localparam logic [CNT_W-1:0] MAX = '1;

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> $stable(cnt)); // R1

  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && freerun && cnt == MAX && !wr_en) |=> (cnt == '0 && stat[5])); // R2

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !freerun && cnt == cmp1 && !wr_en) |=> (cnt == '0 && stat[0])); // R3

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((stat & $past(stat)) == $past(stat))); // R5

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & ien)) |=> irq); // R6

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat & ien)) |=> !irq); // R6
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .wr_en  (wr_en),
  .en     (ctrl_en_q),
  .freerun(ctrl_fr_q),
  .step   (step),
  .cnt    (cnt),
  .cmp1   (cmp_q[CNT_W-1:0]),
  .stat   (stat_q),
  .ien    (ien_q),
  .irq    (irq)
);

// File: tb/tb_cmp_timer.sv
module tb_cmp_timer;
  localparam int CW = 8;

  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        irq;

  int checks;
  int errors;
  bit done;

  localparam logic [31:0] EN   = 32'h1;
  localparam logic [31:0] EMOD = 32'h2;
  localparam logic [31:0] FR   = 32'h200;
  localparam logic [31:0] SWR  = 32'h8000;

  cmp_timer #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int ticks;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; tick_en = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // reset values (R11)
    rd(3'd0, v); chk("R11 ctrl reset", v, 32'h0);
    rd(3'd4, v); chk("R11 cmp1 reset", v, 32'hFF);
    rd(3'd6, v); chk("R11 cmp3 reset", v, 32'hFF);
    rd(3'd2, v); chk("R11 status reset", v, 32'h0);
    chk("R6 irq reset", {31'b0, irq}, 32'h0);

    // disabled counter holds; clock-source field stored, no effect (R1, R11)
    wr(3'd0, 32'h1C0);
    idle(5);
    rd(3'd7, v); chk("R1 hold while disabled", v, 32'h0);
    rd(3'd0, v); chk("R11 ctrl readback", v, 32'h1C0);

    // prescale sweep, steady and toggling tick_en (R7, R1)
    for (int p = 0; p < 4; p++) begin
      for (int alt = 0; alt < 2; alt++) begin
        wr(3'd0, SWR);
        wr(3'd1, 32'(p));
        wr(3'd0, EN | FR);
        ticks = 0;
        for (int m = 1; m <= 12; m++) begin
          tick_en = (alt == 1) ? ((m % 2) == 1) : 1'b1;
          if (tick_en) ticks++;
          @(negedge clk);
          rd(3'd7, v);
          chk(alt ? "R1 tick gating" : "R7 prescale", v, 32'(ticks / (p + 1)));
        end
        tick_en = 1'b1;
      end
    end

    // free-run wrap and flags, interrupt path, write-1-clear (R2, R4, R12, R6, R5)
    wr(3'd0, SWR);
    wr(3'd7, 32'hFC);
    rd(3'd7, v); chk("R12 count load", v, 32'hFC);
    wr(3'd0, EN | FR);
    idle(3);
    rd(3'd7, v); chk("R2 at all-ones", v, 32'hFF);
    rd(3'd2, v); chk("R4 no flag before wrap", v, 32'h0);
    idle(1);
    rd(3'd7, v); chk("R2 wrapped to zero", v, 32'h0);
    rd(3'd2, v); chk("R4 rollover and compare flags", v, 32'h27);
    chk("R6 irq masked", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'h20);
    chk("R6 irq one cycle late", {31'b0, irq}, 32'h0);
    idle(1);
    chk("R6 irq raised", {31'b0, irq}, 32'h1);
    wr(3'd2, 32'h20);
    rd(3'd2, v); chk("R5 write-1 clear", v, 32'h07);
    idle(1);
    chk("R6 irq dropped", {31'b0, irq}, 32'h0);

    // restart mode sweep, compare 1 = 5 (R3, R4)
    wr(3'd0, SWR);
    wr(3'd4, 32'h5);
    wr(3'd0, EN);
    for (int m = 1; m <= 20; m++) begin
      @(negedge clk);
      rd(3'd7, v); chk("R3 restart period", v, 32'(m % 6));
      if (m == 5) begin rd(3'd2, v); chk("R4 no match flag yet", v, 32'h0); end
      if (m == 6) begin rd(3'd2, v); chk("R4 match flag ch1", v, 32'h1); end
    end
    idle(2);
    wr(3'd4, 32'h9);
    rd(3'd7, v); chk("R3 cmp1 write clears count", v, 32'h0);
    idle(9);
    rd(3'd7, v); chk("R3 new limit reached", v, 32'h9);
    idle(1);
    rd(3'd7, v); chk("R3 new limit restart", v, 32'h0);

    // enable-mode restart versus resume (R8)
    wr(3'd0, SWR);
    wr(3'd0, EN | FR);
    idle(10);
    wr(3'd0, 32'h0);
    idle(3);
    rd(3'd7, v); chk("R1 hold after disable", v, 32'd11);
    wr(3'd0, EN | FR);
    idle(2);
    rd(3'd7, v); chk("R8 resume without restart bit", v, 32'd13);
    wr(3'd0, 32'h0);
    wr(3'd0, EN | FR | EMOD);
    rd(3'd7, v); chk("R8 restart on enable", v, 32'h0);
    idle(3);
    rd(3'd7, v); chk("R8 counting after restart", v, 32'd3);

    // forced events (R9)
    wr(3'd0, SWR);
    wr(3'd0, 32'hC000_0000);
    rd(3'd2, v); chk("R9 forced ch2 ch3", v, 32'h06);
    rd(3'd0, v); chk("R9 force bits read 0", v, 32'h0);
    idle(3);
    rd(3'd7, v); chk("R9 force leaves counter off", v, 32'h0);

    // software reset (R10)
    wr(3'd1, 32'h7);
    wr(3'd3, 32'h27);
    wr(3'd5, 32'h3);
    wr(3'd0, EN | FR);
    idle(3);
    chk("R6 irq from forced flags", {31'b0, irq}, 32'h1);
    wr(3'd0, SWR | EN);
    rd(3'd0, v); chk("R10 ctrl cleared", v, 32'h0);
    rd(3'd1, v); chk("R10 prescale cleared", v, 32'h0);
    rd(3'd3, v); chk("R10 enable mask cleared", v, 32'h0);
    rd(3'd5, v); chk("R10 cmp2 all-ones", v, 32'hFF);
    rd(3'd2, v); chk("R10 status cleared", v, 32'h0);
    rd(3'd7, v); chk("R10 count cleared", v, 32'h0);
    idle(2);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
    rd(3'd7, v); chk("R10 stays disabled", v, 32'h0);

    done = 1;
    finish_run();
  end
endmodule